// File: doc/BRIEF.md
# Cache Line Fill State Selector

This block picks the coherence state for a data cache line at two moments. The first is when a cacheable read miss fills the line. The second is when a write to a line held as shared completes on the external bus. It combines two inputs to make the choice:
- a writeback/writethrough input driven by the system.
- the page writethrough attribute of the access.

The line is marked shared when the system asks for writethrough or the page is writethrough. It is marked exclusive when the system asks for writeback on a page that is not writethrough. A shared line sends every write to it out on the external bus. A later write hit to an exclusive line moves that line to modified.

The system input is taken once per bus cycle. The capture happens on the first clock edge at which either a data-ready beat or an early next-address indication is seen. Any readies later in the same cycle are ignored, including the trailing beats of a burst fill. The input is taken only for memory reads and for memory writes that are not writebacks. Every other cycle kind ignores it and produces no state.

The result is a 2-bit line state with a one-cycle valid strobe. A surrounding cache controller writes that state into its tag array.

Top module: `line_fill_state_sel`

## Requirements
- R1: After reset, and on the first cycle after reset is released, `stateValid` is 0 and `lineState` is 2'b00 (invalid).
- R2: The state emitted for a cacheable fill (`cycKind` 0) or a write to a shared line (`cycKind` 2) is shared, 2'b01, if the captured `wbSel` is 0 or `pwt` is 1. `pwt` is taken on the cycle-start edge.
- R3: In those same two cycle kinds, the emitted state is exclusive, 2'b10, if the captured `wbSel` is 1 and `pwt` is 0.
- R4: A `writeHit` with `hitState` exclusive (2'b10) or modified (2'b11) yields `stateValid` high with `lineState` 2'b11 on the next cycle. A `writeHit` with `hitState` shared or invalid yields no strobe.
- R5: `wbSel` is captured on the first edge within a cycle at which `brdy` or `nextAddr` is high. Its value during the remaining readies of a burst has no effect on the result.
- R6: If `nextAddr` is seen before the first `brdy`, the capture happens at `nextAddr`. Later `brdy` or `nextAddr` in the same cycle do not capture again.
- R7: Cycle kinds 1 (noncacheable memory read), 3 (writeback write), 4 (I/O read), 5 (I/O write), 6 (interrupt acknowledge) and 7 (special) produce no `stateValid` strobe.
- R8: A cycle of kind 0 completes on its BEAT_COUNT-th `brdy` (default 4), and every other kind completes on its first `brdy`. The fill or shared-write strobe is high for exactly the one cycle after the completing edge.
- R9: A `cycStart` while a cycle is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cycStart | input | 1 | Start of a bus cycle; `cycKind` and `pwt` are taken on this edge |
| cycKind | input | 3 | Cycle kind: 0 fill, 1 noncacheable read, 2 shared-line write, 3 writeback write, 4 I/O read, 5 I/O write, 6 interrupt acknowledge, 7 special |
| brdy | input | 1 | Data ready beat, active high |
| nextAddr | input | 1 | Early next-address indication, active high |
| wbSel | input | 1 | System line policy: 1 writeback, 0 writethrough |
| pwt | input | 1 | Page writethrough attribute |
| writeHit | input | 1 | A write hit the line described by `hitState` |
| hitState | input | 2 | Current state of the hit line: 00 I, 01 S, 10 E, 11 M |
| lineState | output | 2 | Chosen line state: 00 I, 01 S, 10 E, 11 M |
| stateValid | output | 1 | One-cycle strobe that `lineState` is a new decision |

## Verification
The block holds very little hidden state: a captured policy bit, a latched page attribute, a beat count and a capture-done flag. Each of these shows up at the ports no later than the end of the cycle that uses it. A wrongly captured policy bit, or a recapture on a later beat, gives the wrong shared or exclusive value on the strobe one cycle after the completing ready. A beat count that is off gives a strobe that arrives a beat early, arrives late, or never comes. The bench therefore varies the policy input between the capture edge and the later beats, and checks both the value and the exact cycle of every strobe.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  typedef enum logic [1:0] {
    LINE_INV = 2'b00,
    LINE_SHR = 2'b01,
    LINE_EXC = 2'b10,
    LINE_MOD = 2'b11
  } lineState_e;

  typedef enum logic [2:0] {
    KIND_FILL    = 3'd0,
    KIND_RD_NC   = 3'd1,
    KIND_WR_SHR  = 3'd2,
    KIND_WR_WB   = 3'd3,
    KIND_IO_RD   = 3'd4,
    KIND_IO_WR   = 3'd5,
    KIND_INTA    = 3'd6,
    KIND_SPECIAL = 3'd7
  } cycKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic startLatch;  // new cycle accepted this edge
    logic capture;     // policy input taken this edge
    logic emitFill;    // cycle completes with a state decision
    logic promote;     // write hit on an owned line
  } ctrlStrobe_t;

  // Cycle kinds in which the policy input matters
  function automatic logic isSampledKind(cycKind_e k);
    return (k == KIND_FILL) || (k == KIND_RD_NC) || (k == KIND_WR_SHR);
  endfunction

  // Cycle kinds that end with a line state
  function automatic logic isStateKind(cycKind_e k);
    return (k == KIND_FILL) || (k == KIND_WR_SHR);
  endfunction

endpackage

// File: rtl/lfs_ctrl.sv
module lfs_ctrl
  import lfs_pkg::*;
#(
  parameter int BEAT_COUNT = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cycStart,
  input  logic [2:0]  cycKind,
  input  logic        brdy,
  input  logic        nextAddr,
  input  logic        writeHit,
  input  logic [1:0]  hitState,
  output ctrlStrobe_t strobe
);
  localparam int CNT_W = (BEAT_COUNT > 1) ? $clog2(BEAT_COUNT) : 1;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEAT_COUNT - 1);

  logic             busy;
  logic             captured;
  cycKind_e         kindQ;
  logic [CNT_W-1:0] beatCnt;

  logic handshake;
  logic lastBeat;

  always_comb begin
    handshake = busy && (brdy || nextAddr);
    // A burst fill ends on its final beat, every other kind on its first ready
    lastBeat  = busy && brdy &&
                ((kindQ == KIND_FILL) ? (beatCnt == LAST_BEAT) : 1'b1);

    strobe.startLatch = !busy && cycStart;
    strobe.capture    = handshake && !captured && isSampledKind(kindQ);
    strobe.emitFill   = lastBeat && isStateKind(kindQ);
    // A completing cycle wins over a write hit on the same edge
    strobe.promote    = writeHit &&
                        ((hitState == LINE_EXC) || (hitState == LINE_MOD)) &&
                        !strobe.emitFill;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      captured <= 1'b0;
      kindQ    <= KIND_FILL;
      beatCnt  <= '0;
    end else if (strobe.startLatch) begin
      busy     <= 1'b1;
      captured <= 1'b0;
      kindQ    <= cycKind_e'(cycKind);
      beatCnt  <= '0;
    end else if (busy) begin
      if (handshake) captured <= 1'b1;
      if (brdy)      beatCnt  <= beatCnt + 1'b1;
      if (lastBeat)  busy     <= 1'b0;
    end
  end

endmodule

// File: rtl/lfs_data.sv
module lfs_data
  import lfs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  ctrlStrobe_t strobe,
  input  logic        wbSel,
  input  logic        pwt,
  output logic [1:0]  lineState,
  output logic        stateValid
);
  logic       wbQ;
  logic       pwtQ;
  logic       wbEff;
  lineState_e fillState;

  always_comb begin
    // On a single-beat cycle the capture and the decision share one edge
    wbEff     = strobe.capture ? wbSel : wbQ;
    fillState = (!wbEff || pwtQ) ? LINE_SHR : LINE_EXC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbQ        <= 1'b0;
      pwtQ       <= 1'b0;
      lineState  <= LINE_INV;
      stateValid <= 1'b0;
    end else begin
      if (strobe.startLatch) pwtQ <= pwt;
      if (strobe.capture)    wbQ  <= wbSel;
      if (strobe.emitFill) begin
        lineState  <= fillState;
        stateValid <= 1'b1;
      end else if (strobe.promote) begin
        lineState  <= LINE_MOD;
        stateValid <= 1'b1;
      end else begin
        stateValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/line_fill_state_sel.sv
module line_fill_state_sel
  import lfs_pkg::*;
#(
  parameter int BEAT_COUNT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cycStart,
  input  logic [2:0] cycKind,
  input  logic       brdy,
  input  logic       nextAddr,
  input  logic       wbSel,
  input  logic       pwt,
  input  logic       writeHit,
  input  logic [1:0] hitState,
  output logic [1:0] lineState,
  output logic       stateValid
);
  ctrlStrobe_t strobe;

  lfs_ctrl #(.BEAT_COUNT(BEAT_COUNT)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cycStart (cycStart),
    .cycKind  (cycKind),
    .brdy     (brdy),
    .nextAddr (nextAddr),
    .writeHit (writeHit),
    .hitState (hitState),
    .strobe   (strobe)
  );

  lfs_data u_data (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .wbSel      (wbSel),
    .pwt        (pwt),
    .lineState  (lineState),
    .stateValid (stateValid)
  );

endmodule

// File: rtl/lfs_checker.sv
module lfs_checker (
  input logic       clk,
  input logic       rst,
  input logic       brdy,
  input logic       writeHit,
  input logic [1:0] hitState,
  input logic [1:0] lineState,
  input logic       stateValid
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!stateValid && lineState == 2'b00));

  assert_strobe_not_invalid_R2: assert property (@(posedge clk) disable iff (rst)
    stateValid |-> (lineState != 2'b00));

  assert_exclusive_hit_promotes_R4: assert property (@(posedge clk) disable iff (rst)
    (writeHit && hitState == 2'b10 && !brdy) |=> (stateValid && lineState == 2'b11));

  assert_modified_needs_hit_R4: assert property (@(posedge clk) disable iff (rst)
    (stateValid && lineState == 2'b11) |-> $past(writeHit));

  assert_fill_follows_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (stateValid && lineState != 2'b11) |-> $past(brdy));

endmodule

bind line_fill_state_sel lfs_checker u_lfs_checker (
  .clk        (clk),
  .rst        (rst),
  .brdy       (brdy),
  .writeHit   (writeHit),
  .hitState   (hitState),
  .lineState  (lineState),
  .stateValid (stateValid)
);

// File: tb/line_fill_state_sel_bench.sv
`timescale 1ns/1ps
module line_fill_state_sel_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cycStart = 1'b0;
  logic [2:0] cycKind = 3'd0;
  logic       brdy = 1'b0;
  logic       nextAddr = 1'b0;
  logic       wbSel = 1'b0;
  logic       pwt = 1'b0;
  logic       writeHit = 1'b0;
  logic [1:0] hitState = 2'b00;
  logic [1:0] lineState;
  logic       stateValid;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  line_fill_state_sel #(.BEAT_COUNT(4)) u_line_fill_state_sel (
    .clk(clk), .rst(rst), .cycStart(cycStart), .cycKind(cycKind),
    .brdy(brdy), .nextAddr(nextAddr), .wbSel(wbSel), .pwt(pwt),
    .writeHit(writeHit), .hitState(hitState),
    .lineState(lineState), .stateValid(stateValid)
  );

  // {kind[2:0], pwt, wbAtCapture, wbLater, naLead, expValid, expState[1:0]}
  localparam logic [9:0] VEC [0:14] = '{
    {3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10},
    {3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b01},
    {3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'b01},
    {3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b10},
    {3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b01},
    {3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10},
    {3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01},
    {3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2'b01},
    {3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b10},
    {3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00},
    {3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00},
    {3'd4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00},
    {3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00},
    {3'd6, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00},
    {3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic runVector(input int idx, input logic [9:0] v);
    logic [2:0] k;
    logic p, w0, wl, na, expV;
    logic [1:0] expS, st;
    int beats, cnt, seenAt;
    k = v[9:7]; p = v[6]; w0 = v[5]; wl = v[4]; na = v[3]; expV = v[2]; expS = v[1:0];
    st = 2'b00; cnt = 0; seenAt = -1;
    beats = (k == 3'd0) ? 4 : 1;
    @(negedge clk);
    cycStart = 1'b1; cycKind = k; pwt = p; wbSel = wl;
    @(negedge clk);
    cycStart = 1'b0; pwt = !p;  // later page attribute must not matter
    if (na) begin
      nextAddr = 1'b1; wbSel = w0;
      @(negedge clk);
      if (stateValid) cnt++;
      nextAddr = 1'b0; wbSel = wl;
    end
    for (int i = 0; i <= beats; i++) begin
      brdy  = (i < beats);
      wbSel = (i == 0 && !na) ? w0 : wl;
      nextAddr = (na && i == 1);  // late next-address must not recapture
      @(negedge clk);
      if (stateValid) begin cnt++; seenAt = i; st = lineState; end
    end
    brdy = 1'b0; nextAddr = 1'b0;
    if (expV) begin
      check(cnt == 1 && seenAt == beats - 1,
            $sformatf("R8 vector %0d strobe count/beat", idx), cnt * 10 + seenAt, 10 + beats - 1);
      check(st == expS,
            $sformatf("R2 R3 R5 R6 vector %0d state", idx), st, expS);
    end else begin
      check(cnt == 0, $sformatf("R7 vector %0d unexpected strobe", idx), cnt, 0);
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(stateValid == 1'b0, "R1 valid after reset", stateValid, 0);
    check(lineState == 2'b00, "R1 state after reset", lineState, 0);

    for (int n = 0; n < 15; n++) runVector(n, VEC[n]);

    // R4: write hit on exclusive line
    @(negedge clk);
    writeHit = 1'b1; hitState = 2'b10;
    @(negedge clk);
    writeHit = 1'b0;
    check(stateValid && lineState == 2'b11, "R4 exclusive hit to modified",
          {stateValid, lineState}, 7);
    @(negedge clk);
    check(stateValid == 1'b0, "R8 promote strobe one cycle", stateValid, 0);

    // R4: write hit on modified line stays modified
    writeHit = 1'b1; hitState = 2'b11;
    @(negedge clk);
    writeHit = 1'b0;
    check(stateValid && lineState == 2'b11, "R4 modified hit stays modified",
          {stateValid, lineState}, 7);

    // R4: write hit on shared or invalid line gives no strobe
    writeHit = 1'b1; hitState = 2'b01;
    @(negedge clk);
    check(stateValid == 1'b0, "R4 shared hit no strobe", stateValid, 0);
    hitState = 2'b00;
    @(negedge clk);
    writeHit = 1'b0;
    check(stateValid == 1'b0, "R4 invalid hit no strobe", stateValid, 0);

    // R9: restart during an I/O read is ignored
    @(negedge clk);
    cycStart = 1'b1; cycKind = 3'd4; pwt = 1'b0; wbSel = 1'b1;
    @(negedge clk);
    cycKind = 3'd2;  // second start while busy
    @(negedge clk);
    cycStart = 1'b0; brdy = 1'b1;
    @(negedge clk);
    brdy = 1'b0;
    check(stateValid == 1'b0, "R9 restart while busy ignored", stateValid, 0);
    @(negedge clk);
    check(stateValid == 1'b0, "R9 no late strobe", stateValid, 0);

    // R1: reset in mid-run clears the state
    writeHit = 1'b1; hitState = 2'b10;
    @(negedge clk);
    writeHit = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(stateValid == 1'b0 && lineState == 2'b00, "R1 reset clears state",
          {stateValid, lineState}, 0);

    finishRun();
  end

endmodule